// File: doc/BRIEF.md
# Mid-Level Cache Line Miss Controller

This block follows the coherence state of one line held in a private mid-level cache. The line sits between an inner (per-core) cache and a shared outer level in a three-level MESI hierarchy. It takes requests from the inner cache (load, store, replace), invalidations from the shared level, and data responses that are either shared or exclusive. Shared data may come from the shared level or from a peer cache. The block answers with GETS requests, invalidation acknowledgements, plain or exclusive unblocks, and fills to the inner cache tagged normal, exclusive or stale.

The main case it covers is an invalidation that overtakes the fill data. This happens when a remote writer's invalidation reaches the line after the local GETS was sent but before its data came back. The controller acknowledges that invalidation at once, so the remote writer never waits, and moves to the transient state IS_I. When the late data arrives, it is handed to the inner cache once as stale data (usable for the pending load, not for storage) and the line falls back to I. Requests that arrive while the line is in a transient state wait in a small in-order holding queue and are replayed once the line is stable.

States:
- Stable: I, S, E, M.
- Transient: IS (GETS sent, waiting for data) and IS_I (GETS sent, invalidation already acknowledged).

Transitions:
- I --load--> IS
- IS --inv--> IS_I
- IS_I --inv--> IS_I
- IS --data--> S
- IS_I --data--> I
- IS/IS_I --exclusive data--> E
- S/E/M --inv--> I
- E/M --store--> M
- any stable state --replace--> I

Top module: `mlc_line_ctrl`

## Requirements
- R1: A load (`req_op_i`=0) that is serviced in state I produces a one-cycle `gets_o` pulse in the cycle after it is accepted, and `state_o` becomes IS (encoding 4) in that same cycle.
- R2: An invalidation in IS or IS_I is never stalled. `inv_ack_o` pulses in the following cycle and the state becomes IS_I (encoding 5), even while requests are held.
- R3: A shared response (`rsp_excl_i`=0, `rsp_peer_i`=0) in IS moves the line to S (encoding 1). In the next cycle it gives `fwd_valid_o` with `fwd_kind_o`=0 and the response data, and `unblock_o` stays 0.
- R4: A shared response from the shared level in IS_I gives one fill with `fwd_kind_o`=2 (stale) that carries the response data and dirty flag. The line ends in I (encoding 0).
- R5: A shared response from a peer cache (`rsp_peer_i`=1) pulses `unblock_o`. In IS the line ends in S with a normal fill; in IS_I it ends in I with a stale fill.
- R6: An exclusive response (`rsp_excl_i`=1) in IS or IS_I moves the line to E (encoding 2). It gives a fill with `fwd_kind_o`=1 and a pulse on `unblock_excl_o`.
- R7: Requests that arrive in IS or IS_I are held and produce no output while held. Once the line is stable they are replayed one per cycle in arrival order. A load in S, E or M, or a store in E or M, gives a `hit_o` pulse.
- R8: An invalidation in S, E or M pulses `inv_ack_o` and moves the line to I. In I it is acknowledged and the line stays in I.
- R9: An invalidation and a shared response in the same cycle while in IS are handled invalidation first. Exactly one acknowledgement and one stale fill result, and the line ends in I.
- R10: A response that arrives when the line is in neither IS nor IS_I has no effect: no fill, no unblock, and the state is unchanged.
- R11: A store (`req_op_i`=1) in E or M moves the line to M (encoding 3). A replace (`req_op_i`=2) in any stable state moves it to I. A store in I or S leaves the state unchanged and gives no `hit_o`.
- R12: After reset the line is in I, every pulse output is 0 and `req_ready_o` is 1.
- R13: `req_ready_o` drops to 0 while the holding queue holds HOLD_DEPTH requests and returns to 1 once it drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Inner-cache request present |
| req_op_i | input | 2 | Request kind: 0 load, 1 store, 2 replace |
| req_ready_o | output | 1 | Request can be taken (holding queue not full) |
| inv_valid_i | input | 1 | Invalidation from the shared level |
| rsp_valid_i | input | 1 | Data response present |
| rsp_excl_i | input | 1 | Response grants exclusive ownership |
| rsp_peer_i | input | 1 | Shared response supplied by a peer cache |
| rsp_data_i | input | DATA_W | Response block contents |
| rsp_dirty_i | input | 1 | Response dirty flag |
| gets_o | output | 1 | GETS request to the shared level |
| inv_ack_o | output | 1 | Invalidation acknowledgement |
| unblock_o | output | 1 | Unblock to the shared level |
| unblock_excl_o | output | 1 | Exclusive unblock to the shared level |
| fwd_valid_o | output | 1 | Fill to the inner cache |
| fwd_kind_o | output | 2 | Fill tag: 0 normal, 1 exclusive, 2 stale |
| fwd_data_o | output | DATA_W | Fill block contents |
| fwd_dirty_o | output | 1 | Fill dirty flag |
| hit_o | output | 1 | Request serviced as a hit |
| state_o | output | 3 | Line state: 0 I, 1 S, 2 E, 3 M, 4 IS, 5 IS_I |

## Verification
Every result of this block is registered once. So a GETS, an acknowledgement, an unblock, a fill, a hit or a state change is due exactly one clock edge after the input that causes it. A replayed request is due one edge after the line has become stable, and each further held request one edge after that. The bench drives each stimulus for one cycle starting at a falling edge. It samples at the next falling edge, and walks held requests forward one falling edge at a time. In that way every check lands in the cycle its result is due and in no other. The overtaking-invalidation race is replayed from a cleared line, and the acknowledgement and stale-fill pulses it produces are counted by a monitor.

// File: rtl/mlc_pkg.sv
package mlc_pkg;

    typedef enum logic [2:0] {
        ST_I   = 3'd0,
        ST_S   = 3'd1,
        ST_E   = 3'd2,
        ST_M   = 3'd3,
        ST_IS  = 3'd4,
        ST_ISI = 3'd5
    } line_state_e;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_REPL  = 2'd2,
        OP_NONE  = 2'd3
    } req_op_e;

    typedef enum logic [1:0] {
        FWD_NORM  = 2'd0,
        FWD_EXCL  = 2'd1,
        FWD_STALE = 2'd2
    } fwd_kind_e;

    function automatic logic is_stable(input line_state_e s);
        return (s == ST_I) || (s == ST_S) || (s == ST_E) || (s == ST_M);
    endfunction

    function automatic logic is_fill_wait(input line_state_e s);
        return (s == ST_IS) || (s == ST_ISI);
    endfunction

endpackage

// File: rtl/mlc_hold_fifo.sv
module mlc_hold_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[wr_q] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= bump(wr_q);
            if (pop)  rd_q <= bump(rd_q);
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign dout  = mem_q[rd_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));

endmodule

// File: rtl/mlc_line_fsm.sv
module mlc_line_fsm
    import mlc_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_valid,
    input  logic              rsp_valid,
    input  logic              rsp_excl,
    input  logic              rsp_peer,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              rsp_dirty,
    input  logic              op_valid,
    input  req_op_e           op,
    output line_state_e       state_q,
    output logic              gets_q,
    output logic              ack_q,
    output logic              unblock_q,
    output logic              unblock_excl_q,
    output logic              fwd_valid_q,
    output fwd_kind_e         fwd_kind_q,
    output logic [DATA_W-1:0] fwd_data_q,
    output logic              fwd_dirty_q,
    output logic              hit_q
);
    line_state_e       st_inv, st_nxt;
    logic              gets_n, ack_n, unblock_n, unblock_excl_n;
    logic              fwd_valid_n, fwd_dirty_n, hit_n;
    fwd_kind_e         fwd_kind_n;
    logic [DATA_W-1:0] fwd_data_n;

    always_comb begin
        st_inv         = state_q;
        st_nxt         = state_q;
        gets_n         = 1'b0;
        ack_n          = 1'b0;
        unblock_n      = 1'b0;
        unblock_excl_n = 1'b0;
        fwd_valid_n    = 1'b0;
        fwd_kind_n     = FWD_NORM;
        fwd_data_n     = '0;
        fwd_dirty_n    = 1'b0;
        hit_n          = 1'b0;

        // Step 1: invalidation, acknowledged in every state.
        if (inv_valid) begin
            ack_n = 1'b1;
            unique case (state_q)
                ST_IS, ST_ISI: st_inv = ST_ISI;
                default:       st_inv = ST_I;
            endcase
        end
        st_nxt = st_inv;

        // Step 2: data response, seen against the post-invalidation state.
        if (rsp_valid && is_fill_wait(st_inv)) begin
            fwd_valid_n = 1'b1;
            fwd_data_n  = rsp_data;
            fwd_dirty_n = rsp_dirty;
            if (rsp_excl) begin
                st_nxt         = ST_E;
                fwd_kind_n     = FWD_EXCL;
                unblock_excl_n = 1'b1;
            end else begin
                unblock_n = rsp_peer;
                unique case (st_inv)
                    ST_IS: begin
                        st_nxt     = ST_S;
                        fwd_kind_n = FWD_NORM;
                    end
                    default: begin
                        st_nxt     = ST_I;
                        fwd_kind_n = FWD_STALE;
                    end
                endcase
            end
        end

        // Step 3: request; only offered when stable and no message is present.
        if (op_valid) begin
            unique case (op)
                OP_LOAD: begin
                    if (state_q == ST_I) begin
                        gets_n = 1'b1;
                        st_nxt = ST_IS;
                    end else begin
                        hit_n = 1'b1;
                    end
                end
                OP_STORE: begin
                    if ((state_q == ST_E) || (state_q == ST_M)) begin
                        hit_n  = 1'b1;
                        st_nxt = ST_M;
                    end
                end
                OP_REPL:  st_nxt = ST_I;
                default:  st_nxt = st_inv;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_I;
        end else begin
            state_q <= st_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gets_q         <= 1'b0;
            ack_q          <= 1'b0;
            unblock_q      <= 1'b0;
            unblock_excl_q <= 1'b0;
            fwd_valid_q    <= 1'b0;
            fwd_kind_q     <= FWD_NORM;
            fwd_data_q     <= '0;
            fwd_dirty_q    <= 1'b0;
            hit_q          <= 1'b0;
        end else begin
            gets_q         <= gets_n;
            ack_q          <= ack_n;
            unblock_q      <= unblock_n;
            unblock_excl_q <= unblock_excl_n;
            fwd_valid_q    <= fwd_valid_n;
            fwd_kind_q     <= fwd_kind_n;
            fwd_data_q     <= fwd_data_n;
            fwd_dirty_q    <= fwd_dirty_n;
            hit_q          <= hit_n;
        end
    end

endmodule

// File: rtl/mlc_line_ctrl.sv
module mlc_line_ctrl
    import mlc_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int HOLD_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [1:0]        req_op_i,
    output logic              req_ready_o,
    input  logic              inv_valid_i,
    input  logic              rsp_valid_i,
    input  logic              rsp_excl_i,
    input  logic              rsp_peer_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    input  logic              rsp_dirty_i,
    output logic              gets_o,
    output logic              inv_ack_o,
    output logic              unblock_o,
    output logic              unblock_excl_o,
    output logic              fwd_valid_o,
    output logic [1:0]        fwd_kind_o,
    output logic [DATA_W-1:0] fwd_data_o,
    output logic              fwd_dirty_o,
    output logic              hit_o,
    output logic [2:0]        state_o
);
    localparam int OP_W = $bits(req_op_e);

    line_state_e     state;
    fwd_kind_e       fwd_kind;
    logic            q_empty, q_full, q_push, q_pop;
    logic [OP_W-1:0] q_dout;
    logic            serve, direct, op_valid;
    req_op_e         op;

    assign serve    = is_stable(state) && !inv_valid_i && !rsp_valid_i;
    assign direct   = req_valid_i && q_empty && serve;
    assign q_push   = req_valid_i && !q_full && !direct;
    assign q_pop    = !q_empty && serve;
    assign op_valid = direct || q_pop;
    assign op       = q_pop ? req_op_e'(q_dout) : req_op_e'(req_op_i);

    mlc_hold_fifo #(
        .DEPTH (HOLD_DEPTH),
        .W     (OP_W)
    ) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .pop   (q_pop),
        .din   (req_op_i),
        .dout  (q_dout),
        .empty (q_empty),
        .full  (q_full)
    );

    mlc_line_fsm #(
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .inv_valid      (inv_valid_i),
        .rsp_valid      (rsp_valid_i),
        .rsp_excl       (rsp_excl_i),
        .rsp_peer       (rsp_peer_i),
        .rsp_data       (rsp_data_i),
        .rsp_dirty      (rsp_dirty_i),
        .op_valid       (op_valid),
        .op             (op),
        .state_q        (state),
        .gets_q         (gets_o),
        .ack_q          (inv_ack_o),
        .unblock_q      (unblock_o),
        .unblock_excl_q (unblock_excl_o),
        .fwd_valid_q    (fwd_valid_o),
        .fwd_kind_q     (fwd_kind),
        .fwd_data_q     (fwd_data_o),
        .fwd_dirty_q    (fwd_dirty_o),
        .hit_q          (hit_o)
    );

    assign req_ready_o = !q_full;
    assign fwd_kind_o  = fwd_kind;
    assign state_o     = state;

endmodule

// File: rtl/mlc_line_ctrl_chk.sv
module mlc_line_ctrl_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic [1:0]        req_op_i,
    input logic              req_ready_o,
    input logic              inv_valid_i,
    input logic              rsp_valid_i,
    input logic              rsp_excl_i,
    input logic              rsp_peer_i,
    input logic [DATA_W-1:0] rsp_data_i,
    input logic              rsp_dirty_i,
    input logic              gets_o,
    input logic              inv_ack_o,
    input logic              unblock_o,
    input logic              unblock_excl_o,
    input logic              fwd_valid_o,
    input logic [1:0]        fwd_kind_o,
    input logic [DATA_W-1:0] fwd_data_o,
    input logic              fwd_dirty_o,
    input logic              hit_o,
    input logic [2:0]        state_o
);
    p_gets_enters_is_r1: assert property (@(posedge clk) disable iff (!rst_n)
        gets_o |-> (state_o == 3'd4));

    p_inv_acked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid_i |=> inv_ack_o);

    p_stale_lands_i_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid_o && fwd_kind_o == 2'd2) |-> (state_o == 3'd0));

    p_excl_fill_e_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid_o && fwd_kind_o == 2'd1) |-> (unblock_excl_o && state_o == 3'd2));

    p_hold_in_transient_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o >= 3'd4) |=> !hit_o);

    p_stray_rsp_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_i && state_o < 3'd4) |=> (!fwd_valid_o && !unblock_o && !unblock_excl_o));

    p_single_unblock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(unblock_o && unblock_excl_o));

endmodule

bind mlc_line_ctrl mlc_line_ctrl_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/mlc_line_ctrl_tb_top.sv
module mlc_line_ctrl_tb_top;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid_i = 1'b0;
    logic [1:0]    req_op_i = 2'd0;
    logic          req_ready_o;
    logic          inv_valid_i = 1'b0;
    logic          rsp_valid_i = 1'b0;
    logic          rsp_excl_i = 1'b0;
    logic          rsp_peer_i = 1'b0;
    logic [DW-1:0] rsp_data_i = '0;
    logic          rsp_dirty_i = 1'b0;
    logic          gets_o, inv_ack_o, unblock_o, unblock_excl_o;
    logic          fwd_valid_o, fwd_dirty_o, hit_o;
    logic [1:0]    fwd_kind_o;
    logic [DW-1:0] fwd_data_o;
    logic [2:0]    state_o;

    int n_chk = 0;
    int n_err = 0;
    int ack_cnt = 0;
    int stale_cnt = 0;

    always #10 clk = ~clk;

    mlc_line_ctrl #(.DATA_W(DW), .HOLD_DEPTH(4)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid_i), .req_op_i(req_op_i), .req_ready_o(req_ready_o),
        .inv_valid_i(inv_valid_i), .rsp_valid_i(rsp_valid_i), .rsp_excl_i(rsp_excl_i),
        .rsp_peer_i(rsp_peer_i), .rsp_data_i(rsp_data_i), .rsp_dirty_i(rsp_dirty_i),
        .gets_o(gets_o), .inv_ack_o(inv_ack_o), .unblock_o(unblock_o),
        .unblock_excl_o(unblock_excl_o), .fwd_valid_o(fwd_valid_o), .fwd_kind_o(fwd_kind_o),
        .fwd_data_o(fwd_data_o), .fwd_dirty_o(fwd_dirty_o), .hit_o(hit_o), .state_o(state_o)
    );

    always @(negedge clk) begin
        if (inv_ack_o) ack_cnt++;
        if (fwd_valid_o && fwd_kind_o == 2'd2) stale_cnt++;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_req(input logic [1:0] op);
        req_valid_i = 1'b1; req_op_i = op;
        step();
        req_valid_i = 1'b0;
    endtask

    task automatic send_inv();
        inv_valid_i = 1'b1;
        step();
        inv_valid_i = 1'b0;
    endtask

    task automatic send_rsp(input logic excl, input logic peer, input logic [DW-1:0] d, input logic dirty);
        rsp_valid_i = 1'b1; rsp_excl_i = excl; rsp_peer_i = peer;
        rsp_data_i = d; rsp_dirty_i = dirty;
        step();
        rsp_valid_i = 1'b0; rsp_excl_i = 1'b0; rsp_peer_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        chk("R12 state", state_o, 0);
        chk("R12 ready", req_ready_o, 1);
        chk("R12 pulses", {gets_o, inv_ack_o, unblock_o, unblock_excl_o, fwd_valid_o, hit_o}, 0);
    endtask

    task automatic t_race();
        int a0, s0;
        a0 = ack_cnt; s0 = stale_cnt;
        send_req(2'd0);
        chk("R1 gets", gets_o, 1);
        chk("R1 state IS", state_o, 4);
        send_inv();
        chk("R2 ack", inv_ack_o, 1);
        chk("R2 state IS_I", state_o, 5);
        send_rsp(1'b0, 1'b0, 64'hA5A5_0000_1234_5678, 1'b1);
        chk("R4 fwd valid", fwd_valid_o, 1);
        chk("R4 fwd stale", fwd_kind_o, 2);
        chk("R4 data", fwd_data_o, 64'hA5A5_0000_1234_5678);
        chk("R4 dirty", fwd_dirty_o, 1);
        chk("R4 state I", state_o, 0);
        step();
        chk("R2 one ack", ack_cnt - a0, 1);
        chk("R4 one stale", stale_cnt - s0, 1);
    endtask

    task automatic t_fill_normal();
        send_req(2'd0);
        send_rsp(1'b0, 1'b0, 64'h1111, 1'b0);
        chk("R3 state S", state_o, 1);
        chk("R3 kind", fwd_kind_o, 0);
        chk("R3 data", fwd_data_o, 64'h1111);
        chk("R3 no unblock", unblock_o, 0);
        send_rsp(1'b1, 1'b0, 64'h2222, 1'b0);
        chk("R10 no fill in S", fwd_valid_o, 0);
        chk("R10 state S kept", state_o, 1);
        send_req(2'd1);
        chk("R11 store in S no hit", hit_o, 0);
        chk("R11 store in S state", state_o, 1);
        send_inv();
        chk("R8 ack in S", inv_ack_o, 1);
        chk("R8 state I", state_o, 0);
        send_rsp(1'b0, 1'b1, 64'h3333, 1'b0);
        chk("R10 no fill in I", {fwd_valid_o, unblock_o}, 0);
        chk("R10 state I kept", state_o, 0);
    endtask

    task automatic t_peer();
        send_req(2'd0);
        send_rsp(1'b0, 1'b1, 64'h4444, 1'b0);
        chk("R5 unblock IS", unblock_o, 1);
        chk("R5 kind IS", fwd_kind_o, 0);
        chk("R5 state S", state_o, 1);
        send_inv();
        send_req(2'd0);
        send_inv();
        send_rsp(1'b0, 1'b1, 64'h5555, 1'b0);
        chk("R5 unblock IS_I", unblock_o, 1);
        chk("R5 kind stale", fwd_kind_o, 2);
        chk("R5 state I", state_o, 0);
    endtask

    task automatic t_excl();
        send_req(2'd0);
        send_inv();
        send_inv();
        chk("R2 second ack", inv_ack_o, 1);
        chk("R2 stays IS_I", state_o, 5);
        send_rsp(1'b1, 1'b0, 64'h6666, 1'b1);
        chk("R6 state E", state_o, 2);
        chk("R6 kind excl", fwd_kind_o, 1);
        chk("R6 unblock excl", unblock_excl_o, 1);
        send_req(2'd1);
        chk("R11 store hit", hit_o, 1);
        chk("R11 state M", state_o, 3);
        send_req(2'd2);
        chk("R11 replace I", state_o, 0);
        send_req(2'd0);
        send_rsp(1'b1, 1'b0, 64'h7777, 1'b0);
        chk("R6 E from IS", state_o, 2);
        send_inv();
        chk("R8 inv E to I", state_o, 0);
    endtask

    task automatic t_hold_order();
        send_req(2'd0);
        send_req(2'd0);
        chk("R7 held no hit", hit_o, 0);
        send_req(2'd2);
        send_rsp(1'b0, 1'b0, 64'h8888, 1'b0);
        chk("R7 fill S", state_o, 1);
        chk("R7 no hit at fill", hit_o, 0);
        step();
        chk("R7 first replay hit", hit_o, 1);
        chk("R7 still S", state_o, 1);
        step();
        chk("R7 second replay I", state_o, 0);
        chk("R7 no hit on replace", hit_o, 0);
        send_req(2'd0);
        send_req(2'd0);
        send_inv();
        chk("R2 ack with held req", inv_ack_o, 1);
        send_rsp(1'b0, 1'b0, 64'h9999, 1'b0);
        chk("R4 stale then I", state_o, 0);
        step();
        chk("R7 replay reissues gets", gets_o, 1);
        chk("R7 replay state IS", state_o, 4);
        send_rsp(1'b0, 1'b0, 64'h1, 1'b0);
        send_inv();
    endtask

    task automatic t_same_cycle();
        int a0;
        send_req(2'd0);
        a0 = ack_cnt;
        inv_valid_i = 1'b1; rsp_valid_i = 1'b1; rsp_data_i = 64'hABCD; rsp_dirty_i = 1'b0;
        step();
        inv_valid_i = 1'b0; rsp_valid_i = 1'b0;
        chk("R9 ack", inv_ack_o, 1);
        chk("R9 stale", fwd_kind_o, 2);
        chk("R9 state I", state_o, 0);
        step();
        chk("R9 one ack", ack_cnt - a0, 1);
    endtask

    task automatic t_full();
        send_req(2'd0);
        for (int i = 0; i < 4; i++) send_req(2'd0);
        chk("R13 not ready", req_ready_o, 0);
        send_rsp(1'b0, 1'b0, 64'h2, 1'b0);
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R13 drain hit", hit_o, 1);
        end
        chk("R13 ready again", req_ready_o, 1);
        send_inv();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_race();
        t_fill_normal();
        t_peer();
        t_excl();
        t_hold_order();
        t_same_cycle();
        t_full();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule